// File: doc/BRIEF.md
# Threshold-Qualified Event Counter

This block is one 64-bit event counter whose increment is shaped by a programmable threshold function. Every clock cycle it receives an unsigned event value from the surrounding logic. Depending on the programmed control code, it adds that value, adds one, or adds nothing. The choice depends on how the value compares with a stored threshold.

There are two families of modes. In the level modes, the counter reacts to the comparison result in the current cycle. In the edge modes, it reacts only to a change in the comparison result from one cycle to the next. When the control code and the threshold are both zero and edge mode is off, the threshold function is bypassed and every event value is accumulated.

Software programs the control code, the threshold and the edge enable through a configuration write port and can read them back. The count itself can be written and is always visible. A global enable gates all accumulation. A one-cycle overflow flag marks the cycle in which the count wraps.

Top module: `thresh_evt_counter`

## Requirements
- R1: With edge mode off, control bits [2:1] pick the condition: 00 counts when value differs from threshold, 01 when equal, 10 when value is greater or equal, 11 when value is less.
- R2: With edge mode off and a nonzero control code, control bit [0]=0 adds the event value on each cycle the condition is true, and bit [0]=1 adds exactly 1; nothing is added while the condition is false.
- R3: All comparisons are unsigned, including event values wider than the threshold.
- R4: With edge mode off and control code and threshold both zero, the event value is added on every enabled cycle.
- R5: With edge mode on, codes 001, 011 and 010 add 1 when the equal result falls, rises, or changes in either direction against the previous cycle.
- R6: With edge mode on, codes 101, 111 and 110 add 1 when the greater-or-equal result rises, falls, or changes in either direction against the previous cycle.
- R7: With edge mode on, codes 000 and 100 never change the count.
- R8: Threshold bits at positions TH_W and above read back as zero and take no part in comparisons.
- R9: A configuration write clears the previous-cycle comparison state, so the first cycle after a write never counts as an edge.
- R10: The count wraps modulo 2^64. The overflow flag is high for exactly the one cycle that follows an update that carried out of bit 63.
- R11: Nothing is added while the enable is low. A count write loads the written value exactly, even if an increment is due in the same cycle.
- R12: After reset the count, the overflow flag and the configuration readback are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Global counting enable |
| evt_val | input | VB_W | Unsigned event value for this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tc | input | 3 | Threshold control code to write |
| cfg_te | input | 1 | Edge-mode enable to write |
| cfg_th | input | 12 | Threshold to write |
| cfg_tc_q | output | 3 | Programmed control code |
| cfg_te_q | output | 1 | Programmed edge enable |
| cfg_th_q | output | 12 | Programmed threshold, upper bits masked |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | CNT_W | Value loaded on a count write |
| cnt_q | output | CNT_W | Current count |
| ovf_pulse | output | 1 | One-cycle overflow indication |

## Verification
The bench builds the block with a 12-bit event value and an 8-bit threshold width. With these values, the threshold masking of R8 is visible, both at readback and in a comparison against a value whose low byte matches. Event values above 255 can be compared against a full-width threshold, so the unsigned compare of R3 meets operands of unequal significance. The count keeps its full 64 bits, so the wrap and the overflow flag are exercised at the true boundary by preloading the count just below 2^64.

// File: rtl/thr_cnt_pkg.sv
package thr_cnt_pkg;
  localparam int TH_FULL_W = 12;

  typedef struct packed {
    logic [2:0]           tc;
    logic                 te;
    logic [TH_FULL_W-1:0] th;
  } thr_cfg_t;

  typedef enum logic [1:0] {
    CMP_NE = 2'b00,
    CMP_EQ = 2'b01,
    CMP_GE = 2'b10,
    CMP_LT = 2'b11
  } cmp_sel_e;
endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
  import thr_cnt_pkg::*;
#(
  parameter int TH_W = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [2:0]           tc_in,
  input  logic                 te_in,
  input  logic [TH_FULL_W-1:0] th_in,
  output thr_cfg_t             cfg_q
);
  localparam logic [TH_FULL_W-1:0] TH_MASK =
    TH_FULL_W'((13'd1 << TH_W) - 13'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (we) begin
      cfg_q.tc <= tc_in;
      cfg_q.te <= te_in;
      cfg_q.th <= th_in & TH_MASK;
    end
  end
endmodule

// File: rtl/thr_cond.sv
module thr_cond
  import thr_cnt_pkg::*;
#(
  parameter int VB_W  = 12,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  thr_cfg_t         cfg,
  input  logic [VB_W-1:0]  evt_val,
  output logic [CNT_W-1:0] inc_amt
);
  localparam int CMP_W = (VB_W > TH_FULL_W) ? VB_W : TH_FULL_W;

  logic [CMP_W-1:0] cmp_vb, cmp_th;
  logic is_eq, is_ge, level_hit, thr_off;
  logic base_now, prev_base, prev_vld, rise, fall, edge_hit;

  assign cmp_vb = CMP_W'(evt_val);
  assign cmp_th = CMP_W'(cfg.th);
  assign is_eq  = (cmp_vb == cmp_th);
  assign is_ge  = (cmp_vb >= cmp_th);

  always_comb begin
    case (cmp_sel_e'(cfg.tc[2:1]))
      CMP_NE:  level_hit = !is_eq;
      CMP_EQ:  level_hit = is_eq;
      CMP_GE:  level_hit = is_ge;
      default: level_hit = !is_ge;
    endcase
  end

  assign thr_off  = (cfg.tc == 3'b000) && (cfg.th == '0);
  assign base_now = cfg.tc[2] ? is_ge : is_eq;
  assign rise     = prev_vld && base_now && !prev_base;
  assign fall     = prev_vld && !base_now && prev_base;

  always_comb begin
    case (cfg.tc[1:0])
      2'b01:   edge_hit = cfg.tc[2] ? rise : fall;
      2'b10:   edge_hit = rise | fall;
      2'b11:   edge_hit = cfg.tc[2] ? fall : rise;
      default: edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || cfg_wr) begin
      prev_vld  <= 1'b0;
      prev_base <= 1'b0;
    end else begin
      prev_vld  <= 1'b1;
      prev_base <= base_now;
    end
  end

  always_comb begin
    if (cfg.te)
      inc_amt = edge_hit ? CNT_W'(1) : '0;
    else if (thr_off)
      inc_amt = CNT_W'(evt_val);
    else if (level_hit)
      inc_amt = cfg.tc[0] ? CNT_W'(1) : CNT_W'(evt_val);
    else
      inc_amt = '0;
  end
endmodule

// File: rtl/cnt_accum.sv
module cnt_accum #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] inc_amt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_q
);
  logic [CNT_W:0] sum_ext;
  assign sum_ext = {1'b0, cnt_q} + {1'b0, inc_amt};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (we) begin
        cnt_q <= wdata;
      end else if (en) begin
        cnt_q <= sum_ext[CNT_W-1:0];
        ovf_q <= sum_ext[CNT_W];
      end
    end
  end
endmodule

// File: rtl/thresh_evt_counter.sv
module thresh_evt_counter
  import thr_cnt_pkg::*;
#(
  parameter int VB_W  = 12,
  parameter int TH_W  = 12,
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic [VB_W-1:0]  evt_val,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_tc,
  input  logic             cfg_te,
  input  logic [11:0]      cfg_th,
  output logic [2:0]       cfg_tc_q,
  output logic             cfg_te_q,
  output logic [11:0]      cfg_th_q,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_pulse
);
  thr_cfg_t         cfg;
  logic [CNT_W-1:0] inc_amt;

  thr_cfg_reg #(.TH_W(TH_W)) cfg_i (
    .clk(clk), .rst(rst), .we(cfg_we),
    .tc_in(cfg_tc), .te_in(cfg_te), .th_in(cfg_th), .cfg_q(cfg)
  );

  thr_cond #(.VB_W(VB_W), .CNT_W(CNT_W)) cond_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_we), .cfg(cfg),
    .evt_val(evt_val), .inc_amt(inc_amt)
  );

  cnt_accum #(.CNT_W(CNT_W)) acc_i (
    .clk(clk), .rst(rst), .en(cnt_en), .we(cnt_we), .wdata(cnt_wdata),
    .inc_amt(inc_amt), .cnt_q(cnt_q), .ovf_q(ovf_pulse)
  );

  assign cfg_tc_q = cfg.tc;
  assign cfg_te_q = cfg.te;
  assign cfg_th_q = cfg.th;
endmodule

// File: rtl/thr_cnt_checker.sv
module thr_cnt_checker #(
  parameter int TH_W  = 12,
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             cnt_en,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [2:0]       cfg_tc_q,
  input logic             cfg_te_q,
  input logic [11:0]      cfg_th_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             ovf_pulse
);
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !cnt_we) |=> $stable(cnt_q));

  a_r11_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(cnt_wdata)));

  a_r7_reserved_edge: assert property (@(posedge clk) disable iff (rst)
    (cfg_te_q && cfg_tc_q[1:0] == 2'b00 && !cnt_we) |=> $stable(cnt_q));

  a_r2_unit_step: assert property (@(posedge clk) disable iff (rst)
    (!cfg_te_q && cfg_tc_q[0] && cnt_en && !cnt_we)
      |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

  a_r10_ovf_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |-> (cnt_q < $past(cnt_q)));

  generate
    if (TH_W < 12) begin : g_mask
      a_r8_th_masked: assert property (@(posedge clk) disable iff (rst)
        (cfg_th_q >> TH_W) == 12'd0);
    end
  endgenerate
endmodule

bind thresh_evt_counter thr_cnt_checker #(.TH_W(TH_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_we(cnt_we),
  .cnt_wdata(cnt_wdata), .cfg_tc_q(cfg_tc_q), .cfg_te_q(cfg_te_q),
  .cfg_th_q(cfg_th_q), .cnt_q(cnt_q), .ovf_pulse(ovf_pulse)
);

// File: tb/thresh_evt_counter_tb.sv
`timescale 1ns/1ps
module thresh_evt_counter_tb_top;
  localparam int VB_W  = 12;
  localparam int TH_W  = 8;
  localparam int CNT_W = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cnt_en = 1'b0;
  logic [VB_W-1:0]  evt_val = '0;
  logic             cfg_we = 1'b0;
  logic [2:0]       cfg_tc = '0;
  logic             cfg_te = 1'b0;
  logic [11:0]      cfg_th = '0;
  logic [2:0]       cfg_tc_q;
  logic             cfg_te_q;
  logic [11:0]      cfg_th_q;
  logic             cnt_we = 1'b0;
  logic [CNT_W-1:0] cnt_wdata = '0;
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  thresh_evt_counter #(.VB_W(VB_W), .TH_W(TH_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .evt_val(evt_val),
    .cfg_we(cfg_we), .cfg_tc(cfg_tc), .cfg_te(cfg_te), .cfg_th(cfg_th),
    .cfg_tc_q(cfg_tc_q), .cfg_te_q(cfg_te_q), .cfg_th_q(cfg_th_q),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q), .ovf_pulse(ovf_pulse)
  );

  // tc[42:40] th[39:28] vb[27:16] expected[15:0]
  localparam logic [42:0] VEC [13] = '{
    {3'd0, 12'd0,   12'd37,   16'd37},   // R4 passthrough
    {3'd0, 12'd10,  12'd37,   16'd37},   // R1 ne, add value
    {3'd0, 12'd10,  12'd10,   16'd0},    // R1 ne false
    {3'd1, 12'd10,  12'd37,   16'd1},    // R2 ne, add one
    {3'd2, 12'd10,  12'd10,   16'd10},   // R1 eq
    {3'd3, 12'd10,  12'd10,   16'd1},    // R2 eq, one
    {3'd3, 12'd10,  12'd11,   16'd0},    // R2 eq false
    {3'd4, 12'd200, 12'd200,  16'd200},  // R1 ge boundary
    {3'd5, 12'd200, 12'd199,  16'd0},    // R1 ge false
    {3'd6, 12'd200, 12'd199,  16'd199},  // R1 lt
    {3'd7, 12'd200, 12'd200,  16'd0},    // R2 lt false at boundary
    {3'd4, 12'd100, 12'd4000, 16'd4000}, // R3 wide value ge
    {3'd6, 12'd255, 12'd2048, 16'd0}     // R3 unsigned lt
  };

  task automatic chk(input string req, input logic [CNT_W-1:0] act,
                     input logic [CNT_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] tc, input logic te, input logic [11:0] th);
    @(negedge clk);
    cfg_we = 1'b1; cfg_tc = tc; cfg_te = te; cfg_th = th;
    cnt_we = 1'b1; cnt_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0; cnt_we = 1'b0;
  endtask

  task automatic step(input logic [VB_W-1:0] v);
    evt_val = v; cnt_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic stop_run();
    cnt_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R12 count", cnt_q, '0);
    chk("R12 ovf", CNT_W'(ovf_pulse), '0);
    chk("R12 cfg", CNT_W'({cfg_tc_q, cfg_te_q, cfg_th_q}), '0);

    for (int i = 0; i < 13; i++) begin
      cfg_write(VEC[i][42:40], 1'b0, VEC[i][39:28]);
      step(VEC[i][27:16]);
      stop_run();
      chk($sformatf("R1/R2/R3/R4 vec%0d", i), cnt_q, CNT_W'(VEC[i][15:0]));
    end

    // R4 over several cycles
    cfg_write(3'd0, 1'b0, 12'd0);
    step(12'd0); step(12'd7); step(12'd300);
    stop_run();
    chk("R4 multi", cnt_q, 64'd307);

    // R8 masking
    cfg_write(3'd3, 1'b0, 12'hFA5);
    chk("R8 readback", CNT_W'(cfg_th_q), 64'h0A5);
    step(12'h0A5); step(12'hFA5);
    stop_run();
    chk("R8 compare", cnt_q, 64'd1);

    // R5 equal edges, th=50
    cfg_write(3'b011, 1'b1, 12'd50);
    step(12'd10); step(12'd50); step(12'd50); step(12'd10); step(12'd50);
    stop_run();
    chk("R5 rise", cnt_q, 64'd2);
    cfg_write(3'b001, 1'b1, 12'd50);
    step(12'd50); step(12'd10); step(12'd50); step(12'd10);
    stop_run();
    chk("R5 fall", cnt_q, 64'd2);
    cfg_write(3'b010, 1'b1, 12'd50);
    step(12'd50); step(12'd10); step(12'd50); step(12'd10);
    stop_run();
    chk("R5 both", cnt_q, 64'd3);

    // R6 ge edges, th=100
    cfg_write(3'b101, 1'b1, 12'd100);
    step(12'd50); step(12'd150); step(12'd150); step(12'd50); step(12'd150);
    stop_run();
    chk("R6 rise", cnt_q, 64'd2);
    cfg_write(3'b111, 1'b1, 12'd100);
    step(12'd50); step(12'd150); step(12'd150); step(12'd50); step(12'd150);
    stop_run();
    chk("R6 fall", cnt_q, 64'd1);
    cfg_write(3'b110, 1'b1, 12'd100);
    step(12'd50); step(12'd150); step(12'd150); step(12'd50); step(12'd150);
    stop_run();
    chk("R6 both", cnt_q, 64'd3);

    // R7 reserved edge codes
    cfg_write(3'b000, 1'b1, 12'd100);
    step(12'd50); step(12'd100); step(12'd50); step(12'd150);
    stop_run();
    chk("R7 code000", cnt_q, 64'd0);
    cfg_write(3'b100, 1'b1, 12'd100);
    step(12'd50); step(12'd150); step(12'd50); step(12'd150);
    stop_run();
    chk("R7 code100", cnt_q, 64'd0);

    // R9 no false edge after write
    cfg_write(3'd0, 1'b0, 12'd0);
    evt_val = 12'd50;
    cfg_write(3'b011, 1'b1, 12'd50);
    step(12'd50); step(12'd50); step(12'd50);
    stop_run();
    chk("R9 no false edge", cnt_q, 64'd0);

    // R11 enable low
    cfg_write(3'd0, 1'b0, 12'd0);
    evt_val = 12'd99; cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 disabled", cnt_q, 64'd0);

    // R11 write priority
    cnt_we = 1'b1; cnt_wdata = 64'h1234_5678_9ABC_DEF0;
    step(12'd99);
    cnt_we = 1'b0;
    stop_run();
    chk("R11 write wins", cnt_q, 64'h1234_5678_9ABC_DEF0);

    // R10 wrap and overflow pulse
    cnt_we = 1'b1; cnt_wdata = 64'hFFFF_FFFF_FFFF_FFFE;
    @(negedge clk);
    cnt_we = 1'b0;
    step(12'd5);
    stop_run();
    chk("R10 wrap", cnt_q, 64'd3);
    chk("R10 ovf high", CNT_W'(ovf_pulse), 64'd1);
    @(negedge clk);
    chk("R10 ovf one cycle", CNT_W'(ovf_pulse), 64'd0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule